// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Trigger and Acceptance Levels

This block is the receive half of a serial port with a queue. Bytes arrive on a one-cycle valid strobe and are kept in a 16-entry first-in first-out store. Software takes them one at a time through a pop strobe, and the oldest byte is always shown on the data output. A control word written by software holds two independent level selectors. The first sets the fill level at which the queue reports itself as full enough to service. The second sets the fill level at which the block stops signalling to the sender that it can take more input.

Two status words are presented. The queue status word carries a "trigger reached" flag and a "data waiting below trigger" flag. The line status word carries a sticky overrun flag, which is set when a byte arrives with all 16 entries occupied. A read strobe on the line status word clears that flag at the next edge. Serial bit timing, transmission and interrupt generation belong to other blocks.

Top module: `rxq_top`

## Requirements
- R1: Bytes are returned in the order they were accepted, and at most 16 are held at once.
- R2: A byte offered while 16 entries are occupied is discarded and sets `line_stat[0]` (overrun) at that edge.
- R3: The overrun flag stays set until a cycle with `line_clr` high, whose edge clears `line_stat` to zero. The value is visible before that edge. An overrun in the same cycle as the clear leaves the flag set.
- R4: `cfg_wdata[8:7]` chooses the trigger level: 00 gives 1 byte, 01 gives 4, 10 gives 8, 11 gives 14.
- R5: With the fill count at or above the trigger level, `fifo_stat[1]` (trigger reached) is 1 and `fifo_stat[0]` (data waiting) is 0.
- R6: With the fill count below the trigger level, `fifo_stat[1]` is 0 and `fifo_stat[0]` is 1 exactly when the count is non-zero.
- R7: `cfg_wdata[11:9]` chooses the acceptance limit: 0 gives 15, 1 gives 1, 2 gives 4, 3 gives 6, 4 gives 8, 5 gives 10, 6 gives 12, 7 gives 14. `rx_ready` is high only while the count is below the limit. A byte offered while `rx_ready` is low is still stored if fewer than 16 entries are held.
- R8: After reset the queue is empty, both selectors are 0 and `fifo_stat` reads 16'h0060. Bits 6 and 5 are always 1 and every bit other than 6, 5, 1 and 0 is always 0.
- R9: `fifo_data` shows the oldest byte, or 0 when empty. A pop removes that byte, and count and flags reflect the removal right after the same edge. A pop of an empty queue changes nothing.
- R10: A push and a pop in the same cycle leave the count unchanged when 1 to 15 entries are held. When the queue is empty, only the push takes effect. When it is full, the push is discarded with overrun and the pop still removes a byte.
- R11: A control write takes effect at the next edge, and bits of `cfg_wdata` outside [11:7] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | High while the count is below the acceptance limit |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word; level selectors in [11:7] |
| fifo_pop | input | 1 | Remove the oldest byte |
| fifo_data | output | 8 | Oldest byte, 0 when empty |
| fifo_stat | output | 16 | Queue status: [1] trigger reached, [0] data waiting, [6:5] fixed ones |
| line_clr | input | 1 | Line status read strobe; clears it at the edge |
| line_stat | output | 16 | Line status: [0] sticky overrun |

## Verification
Every result in this block comes from state captured at one edge and decoded without further registers. A push, pop, control write or line-status read therefore shows on `fifo_data`, `fifo_stat`, `rx_ready` and `line_stat` right after the edge that takes it, with no added latency. The flags and readiness follow the new count, and the new selectors apply from that edge as well. Stimulus changes a few nanoseconds after a rising edge, and each check samples at that same offset after the edge that took the stimulus. The overrun value being cleared is read before its edge, and its cleared value is read after.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned CFG_W       = 16;
  localparam int unsigned STAT_W      = 16;
  localparam int unsigned TRIG_LSB    = 7;
  localparam int unsigned LIMIT_LSB   = 9;

  typedef struct packed {
    logic hit;
    logic waiting;
  } rxq_flags_t;

  // Fill level that raises the trigger-reached flag.
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // Fill level at which the block stops asking for input.
  function automatic int unsigned accept_limit(input logic [2:0] sel);
    case (sel)
      3'd0:    return 15;
      3'd1:    return 1;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 12;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              dropped
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              is_full, is_empty, do_push, do_pop;

  assign is_full  = (cnt_q == CNT_W'(DEPTH));
  assign is_empty = (cnt_q == '0);
  assign do_push  = push_req && !is_full;
  assign do_pop   = pop_req && !is_empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) begin
      wr_d = (wr_q == IDX_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
    if (do_pop) begin
      rd_d = (rd_q == IDX_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; only occupied entries are ever shown.
  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_q] <= push_data;
    end
  end

  assign head    = is_empty ? '0 : mem[rd_q];
  assign count   = cnt_q;
  assign dropped = push_req && is_full;

endmodule

// File: rtl/rxq_levels.sv
module rxq_levels #(
  parameter int unsigned CNT_W = 5
) (
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        trig_sel,
  input  logic [2:0]        limit_sel,
  output rxq_pkg::rxq_flags_t flags,
  output logic              ready
);

  logic [CNT_W-1:0] trig_lvl, limit_lvl;

  assign trig_lvl  = CNT_W'(rxq_pkg::trig_level(trig_sel));
  assign limit_lvl = CNT_W'(rxq_pkg::accept_limit(limit_sel));

  always_comb begin
    flags.hit     = (count >= trig_lvl);
    flags.waiting = !flags.hit && (count != '0);
    ready         = (count < limit_lvl);
  end

endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_evt) flag_d = 1'b0;
    if (set_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/rxq_top.sv
module rxq_top #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              rx_ready,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  input  logic              fifo_pop,
  output logic [DATA_W-1:0] fifo_data,
  output logic [15:0]       fifo_stat,
  input  logic              line_clr,
  output logic [15:0]       line_stat
);

  // Reset: asserted at once, released through two flops.
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Level selectors.
  logic [1:0] trig_q, trig_d;
  logic [2:0] lim_q, lim_d;

  always_comb begin
    trig_d = trig_q;
    lim_d  = lim_q;
    if (cfg_we) begin
      trig_d = cfg_wdata[rxq_pkg::TRIG_LSB  +: 2];
      lim_d  = cfg_wdata[rxq_pkg::LIMIT_LSB +: 3];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      trig_q <= '0;
      lim_q  <= '0;
    end else begin
      trig_q <= trig_d;
      lim_q  <= lim_d;
    end
  end

  logic [CNT_W-1:0]    cnt_w;
  logic                drop_w, ovr_w;
  rxq_pkg::rxq_flags_t flags_w;

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_q),
    .push_req (rx_valid),
    .push_data(rx_byte),
    .pop_req  (fifo_pop),
    .head     (fifo_data),
    .count    (cnt_w),
    .dropped  (drop_w)
  );

  rxq_levels #(.CNT_W(CNT_W)) u_levels (
    .count    (cnt_w),
    .trig_sel (trig_q),
    .limit_sel(lim_q),
    .flags    (flags_w),
    .ready    (rx_ready)
  );

  rxq_ovr u_ovr (
    .clk    (clk),
    .rst_n  (rst_q),
    .set_evt(drop_w),
    .clr_evt(line_clr),
    .flag   (ovr_w)
  );

  assign fifo_stat = {9'd0, 2'b11, 3'd0, flags_w.hit, flags_w.waiting};
  assign line_stat = {15'd0, ovr_w};

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             fifo_pop,
  input logic             line_clr,
  input logic [CNT_W-1:0] cnt,
  input logic [15:0]      fifo_stat,
  input logic [15:0]      line_stat
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R1
  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DEPTH)) && rx_valid |=> line_stat[0]); // R2
  AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    line_stat[0] && !line_clr |=> line_stat[0]); // R3
  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    line_clr && !rx_valid |=> (line_stat == 16'd0)); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_stat[1] && fifo_stat[0])); // R5
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (fifo_stat[1:0] == 2'b00)); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) && fifo_pop && !rx_valid |=> (cnt == '0)); // R9
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && fifo_pop && (cnt != '0) && (cnt != CNT_W'(DEPTH)) |=> $stable(cnt)); // R10

endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .rx_valid (rx_valid),
  .fifo_pop (fifo_pop),
  .line_clr (line_clr),
  .cnt      (cnt_w),
  .fifo_stat(fifo_stat),
  .line_stat(line_stat)
);

// File: tb/sim_rxq_top.sv
module sim_rxq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, cfg_we, fifo_pop, line_clr, rx_ready;
  logic [7:0]  rx_byte, fifo_data;
  logic [15:0] cfg_wdata, fifo_stat, line_stat;

  always #10 clk = ~clk;

  rxq_top u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .fifo_pop(fifo_pop), .fifo_data(fifo_data), .fifo_stat(fifo_stat),
    .line_clr(line_clr), .line_stat(line_stat)
  );

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  // {push, pop, byte, exp hit, exp waiting, exp ready, exp head}
  // control: trigger 4, acceptance limit 6
  localparam logic [20:0] VEC [14] = '{
    {1'b1, 1'b0, 8'hA1, 1'b0, 1'b1, 1'b1, 8'hA1},
    {1'b1, 1'b0, 8'hA2, 1'b0, 1'b1, 1'b1, 8'hA1},
    {1'b1, 1'b0, 8'hA3, 1'b0, 1'b1, 1'b1, 8'hA1},
    {1'b1, 1'b0, 8'hA4, 1'b1, 1'b0, 1'b1, 8'hA1},
    {1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b1, 8'hA2},
    {1'b1, 1'b0, 8'hA6, 1'b1, 1'b0, 1'b1, 8'hA2},
    {1'b1, 1'b0, 8'hA7, 1'b1, 1'b0, 1'b0, 8'hA2},
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA3},
    {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA4},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'hA5},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'hA6},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'hA7},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00}
  };

  task automatic chk(input string req, input string what, input logic [15:0] got,
                     input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    rx_valid = 1'b0; fifo_pop = 1'b0; cfg_we = 1'b0; line_clr = 1'b0;
  endtask

  task automatic write_cfg(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v; tick(); cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; tick(); rx_valid = 1'b0;
  endtask

  task automatic pop();
    fifo_pop = 1'b1; tick(); fifo_pop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rx_byte = 8'h00; cfg_wdata = 16'h0000;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (3) tick();

    // Reset state
    chk("R8", "status after reset", fifo_stat, 16'h0060);
    chk("R7", "ready after reset", {15'd0, rx_ready}, 16'd1);
    chk("R9", "empty head", {8'd0, fifo_data}, 16'h0000);
    chk("R3", "line status after reset", line_stat, 16'h0000);

    // Default trigger of one byte
    push(8'h11);
    chk("R4", "trigger 1 reached", fifo_stat, 16'h0062);
    chk("R1", "single byte head", {8'd0, fifo_data}, 16'h0011);
    pop();
    chk("R9", "status after pop", fifo_stat, 16'h0060);

    // Table walk: trigger 4, limit 6; stray bits outside [11:7] set
    write_cfg(16'hF6FF);
    chk("R11", "status unchanged by config", fifo_stat, 16'h0060);
    for (int i = 0; i < 14; i++) begin
      logic p, q, eh, ew, er;
      logic [7:0] b, ed;
      {p, q, b, eh, ew, er, ed} = VEC[i];
      rx_valid = p; fifo_pop = q; rx_byte = b;
      tick();
      idle();
      chk("R5", "hit flag", {15'd0, fifo_stat[1]}, {15'd0, eh});
      chk("R6", "waiting flag", {15'd0, fifo_stat[0]}, {15'd0, ew});
      chk("R7", "ready at limit 6", {15'd0, rx_ready}, {15'd0, er});
      chk("R10", "head byte", {8'd0, fifo_data}, {8'd0, ed});
    end

    // Trigger 8, limit 15, fill to overflow
    write_cfg(16'h0100);
    for (int k = 0; k < 7; k++) push(8'h30 + 8'(k));
    chk("R4", "below trigger 8", fifo_stat, 16'h0061);
    push(8'h37);
    chk("R4", "at trigger 8", fifo_stat, 16'h0062);
    for (int k = 8; k < 14; k++) push(8'h30 + 8'(k));
    chk("R7", "ready at 14 of 15", {15'd0, rx_ready}, 16'd1);
    push(8'h3E);
    chk("R7", "not ready at 15", {15'd0, rx_ready}, 16'd0);
    push(8'h3F);
    chk("R7", "byte stored while not ready", line_stat, 16'h0000);
    push(8'hEE);
    chk("R2", "overrun on full", line_stat, 16'h0001);
    tick();
    chk("R3", "overrun sticky", line_stat, 16'h0001);
    line_clr = 1'b1;
    chk("R3", "value before clear edge", line_stat, 16'h0001);
    tick();
    line_clr = 1'b0;
    chk("R3", "cleared by read", line_stat, 16'h0000);
    rx_valid = 1'b1; rx_byte = 8'hDD; fifo_pop = 1'b1;
    tick();
    idle();
    chk("R10", "push dropped at full with pop", line_stat, 16'h0001);
    chk("R10", "pop proceeds at full", {8'd0, fifo_data}, 16'h0031);
    line_clr = 1'b1; tick(); line_clr = 1'b0;
    for (int k = 1; k < 16; k++) begin
      chk("R1", "arrival order", {8'd0, fifo_data}, {8'd0, 8'h30 + 8'(k)});
      pop();
    end
    chk("R1", "drained after 16", {8'd0, fifo_data}, 16'h0000);
    pop();
    chk("R9", "empty pop status", fifo_stat, 16'h0060);
    chk("R9", "empty pop head", {8'd0, fifo_data}, 16'h0000);

    // Limit 1, trigger 1, push with pop on empty
    write_cfg(16'h0200);
    chk("R7", "ready with limit 1 empty", {15'd0, rx_ready}, 16'd1);
    rx_valid = 1'b1; rx_byte = 8'h5A; fifo_pop = 1'b1;
    tick();
    idle();
    chk("R10", "push taken on empty", {8'd0, fifo_data}, 16'h005A);
    chk("R7", "not ready at limit 1", {15'd0, rx_ready}, 16'd0);
    chk("R5", "trigger 1 hit", fifo_stat, 16'h0062);
    pop();

    // Overrun in the same cycle as the clear
    for (int k = 0; k < 16; k++) push(8'(k));
    rx_valid = 1'b1; rx_byte = 8'hFF; line_clr = 1'b1;
    tick();
    idle();
    chk("R3", "set wins over clear", line_stat, 16'h0001);
    line_clr = 1'b1; tick(); line_clr = 1'b0;
    chk("R3", "cleared afterwards", line_stat, 16'h0000);
    for (int k = 0; k < 16; k++) pop();
    chk("R8", "status after drain", fifo_stat, 16'h0060);

    finish_run();
  end

endmodule